// File: doc/BRIEF.md
# Indirect Control Register Port with Transmit/Receive Gating

This block is the host-facing register front end of a serial link controller. The host reaches every control and status register through two locations. The first is a pointer register. The second is a data port that reads or writes whichever register the pointer currently selects. Register number 0 is the main control register. Every other register behind the pointer is plain read/write storage.

The main control register carries four kinds of bit. The first is a priority transmit demand, which software sets and the priority scheduler clears. The second is a read-only stopped flag, which start and stop primitives control. The third is a pair of transmitter and receiver disable bits. The fourth is a pair of read-only "engine on" acknowledge flags. A disable request does not cut a frame short. The acknowledge flag drops only when the engine's frame-busy input is low, so software learns from the flag when the engine has really gone quiet. The block drives permit outputs that the transmit and receive engines use to decide whether they may start a new frame.

Top module: `csr_ctl_port`

## Requirements
- R1: A host write with `hostIsData`=0 loads the 16-bit pointer. A host read with `hostIsData`=0 returns the pointer. The pointer resets to 0.
- R2: With `hostIsData`=1, writes and reads reach the register numbered by pointer bits [3:1]. Pointer bit 0 and bits [15:4] do not affect the selection. Registers 1 to 7 read back exactly what was last written to them.
- R3: In control register 0, bit 15 is the priority demand, bit 14 the stopped flag, bit 13 the transmit disable, bit 12 the receive disable, bit 5 the transmitter-on flag and bit 4 the receiver-on flag. All other bits read 0. After reset the register reads 0x4000.
- R4: The stopped flag is 1 from reset. A `primStop` pulse sets it and a `primStart` pulse clears it. Stop takes priority if both are high. Host writes to bit 14 have no effect.
- R5: While stopped, `txPermit` and `rxPermit` are 0 and `engineHold` is 1. One cycle after stop takes effect, the demand, disable and on bits are all 0. Host writes to control register 0 do not change them while stopped. Registers 1 to 7 and the pointer stay writable while stopped.
- R6: Transmit disable is read/write. While it is 1, `txPermit` is 0 from the cycle after the write. This blocks every new transmission, including automatically generated link-management frames.
- R7: The transmitter-on flag clears one cycle after the first clock edge at which the transmit disable is 1 and `txBusy` is 0. It holds its value while `txBusy` stays high. It sets one cycle after the transmit disable reads 0 while not stopped. Host writes to bits 5 and 4 have no effect.
- R8: Receive disable behaves the same way, with `rxBusy`, `rxPermit` and the receiver-on flag. While it is 1 and the block is not stopped, `localBusy` is 1.
- R9: Writing 1 to bit 15 sets the priority demand (`prioDemand`), and writing 0 to it has no effect. A `prioDone` pulse clears the demand. If a set and a `prioDone` fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low bus reset |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostIsData | input | 1 | 0 selects the pointer, 1 selects the data port |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data for the location chosen by `hostIsData` (combinational) |
| primStop | input | 1 | Stop primitive pulse |
| primStart | input | 1 | Start primitive pulse |
| prioDone | input | 1 | Priority scheduler has serviced all active entries |
| txBusy | input | 1 | Transmit engine is in the middle of a frame |
| rxBusy | input | 1 | Receive engine is in the middle of a frame |
| txPermit | output | 1 | Transmit engine may begin a new frame of any kind |
| rxPermit | output | 1 | Receive engine may accept a new frame |
| localBusy | output | 1 | Receiver is in the local-busy state |
| prioDemand | output | 1 | Priority transmit demand is pending |
| engineHold | output | 1 | Engines are held in reset (stopped) |

## Verification
The hardest situation to reach is a disable request that lands while a frame is still in flight. Here the disable bit already reads 1 and the permit output is already low, but the on-flag must stay 1 until the busy input falls. The stimulus raises `txBusy` or `rxBusy` first, then writes the disable and holds busy for several cycles while polling the register. Only then does it drop busy and check that the flag falls exactly one edge later. A second case is hard to reach because it needs both inputs in the same cycle. The bench drives a priority-demand set and `prioDone` together in one cycle to check the set-wins rule.

// File: rtl/csr_port_pkg.sv
package csr_port_pkg;

  // Control register 0 bit positions (software decodes these)
  localparam int BIT_PRIO  = 15;
  localparam int BIT_STOP  = 14;
  localparam int BIT_TXDIS = 13;
  localparam int BIT_RXDIS = 12;
  localparam int BIT_TXON  = 5;
  localparam int BIT_RXON  = 4;

  typedef struct packed {
    logic ptrWr;    // load pointer
    logic csr0Wr;   // write control register 0
    logic plainWr;  // write one of the plain registers
    logic hold;     // engine state held in reset
  } strobe_t;

endpackage

// File: rtl/csr_port_ctrl.sv
module csr_port_ctrl
  import csr_port_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWr,
  input  logic             hostIsData,
  input  logic [SEL_W-1:0] selIdx,
  input  logic             primStop,
  input  logic             primStart,
  input  logic             dtxBit,
  input  logic             drxBit,
  input  logic             txBusy,
  input  logic             rxBusy,
  output strobe_t          strb,
  output logic             stopFlag,
  output logic             txOnQ,
  output logic             rxOnQ
);

  logic selZero;
  assign selZero = (selIdx == '0);

  always_comb begin
    strb.ptrWr   = hostWr && !hostIsData;
    strb.csr0Wr  = hostWr && hostIsData && selZero;
    strb.plainWr = hostWr && hostIsData && !selZero;
    strb.hold    = stopFlag;
  end

  // Stopped flag: set by reset or stop, cleared by start; stop wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          stopFlag <= 1'b1;
    else if (primStop)  stopFlag <= 1'b1;
    else if (primStart) stopFlag <= 1'b0;
  end

  // Engine-on acknowledge flags: drop only at a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOnQ <= 1'b0;
      rxOnQ <= 1'b0;
    end else if (stopFlag) begin
      txOnQ <= 1'b0;
      rxOnQ <= 1'b0;
    end else begin
      if (!dtxBit)      txOnQ <= 1'b1;
      else if (!txBusy) txOnQ <= 1'b0;
      if (!drxBit)      rxOnQ <= 1'b1;
      else if (!rxBusy) rxOnQ <= 1'b0;
    end
  end

endmodule

// File: rtl/csr_port_dpath.sv
module csr_port_dpath
  import csr_port_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_CSR = 8,
  parameter int SEL_LSB = 1,
  localparam int SEL_W  = $clog2(NUM_CSR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              hostIsData,
  input  logic [DATA_W-1:0] wrData,
  input  logic              prioDone,
  input  logic              stopFlag,
  input  logic              txOnQ,
  input  logic              rxOnQ,
  output logic [SEL_W-1:0]  selIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              ptdmdQ,
  output logic              dtxQ,
  output logic              drxQ
);

  logic [DATA_W-1:0] ptrQ;
  logic [DATA_W-1:0] readTbl [NUM_CSR];
  logic [DATA_W-1:0] csr0Val;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ptrQ <= '0;
    else if (strb.ptrWr) ptrQ <= wrData;
  end

  assign selIdx = ptrQ[SEL_LSB +: SEL_W];

  // Writable bits of control register 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptdmdQ <= 1'b0;
      dtxQ   <= 1'b0;
      drxQ   <= 1'b0;
    end else if (strb.hold) begin
      ptdmdQ <= 1'b0;
      dtxQ   <= 1'b0;
      drxQ   <= 1'b0;
    end else begin
      if (strb.csr0Wr && wrData[BIT_PRIO]) ptdmdQ <= 1'b1;
      else if (prioDone)                   ptdmdQ <= 1'b0;
      if (strb.csr0Wr) begin
        dtxQ <= wrData[BIT_TXDIS];
        drxQ <= wrData[BIT_RXDIS];
      end
    end
  end

  always_comb begin
    csr0Val            = '0;
    csr0Val[BIT_PRIO]  = ptdmdQ;
    csr0Val[BIT_STOP]  = stopFlag;
    csr0Val[BIT_TXDIS] = dtxQ;
    csr0Val[BIT_RXDIS] = drxQ;
    csr0Val[BIT_TXON]  = txOnQ;
    csr0Val[BIT_RXON]  = rxOnQ;
  end

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_csr
    if (g == 0) begin : g_main
      assign readTbl[g] = csr0Val;
    end else begin : g_plain
      logic [DATA_W-1:0] storeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                      storeQ <= '0;
        else if (strb.plainWr && selIdx == SEL_W'(g))   storeQ <= wrData;
      end
      assign readTbl[g] = storeQ;
    end
  end

  assign rdData = hostIsData ? readTbl[selIdx] : ptrQ;

endmodule

// File: rtl/csr_ctl_port.sv
module csr_ctl_port
  import csr_port_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_CSR = 8,
  parameter int SEL_LSB = 1,
  localparam int SEL_W  = $clog2(NUM_CSR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostIsData,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              primStop,
  input  logic              primStart,
  input  logic              prioDone,
  input  logic              txBusy,
  input  logic              rxBusy,
  output logic              txPermit,
  output logic              rxPermit,
  output logic              localBusy,
  output logic              prioDemand,
  output logic              engineHold
);

  strobe_t          strb;
  logic [SEL_W-1:0] selIdx;
  logic             stopFlag, txOnQ, rxOnQ, ptdmdQ, dtxQ, drxQ;

  csr_port_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostIsData(hostIsData),
    .selIdx(selIdx), .primStop(primStop), .primStart(primStart),
    .dtxBit(dtxQ), .drxBit(drxQ), .txBusy(txBusy), .rxBusy(rxBusy),
    .strb(strb), .stopFlag(stopFlag), .txOnQ(txOnQ), .rxOnQ(rxOnQ)
  );

  csr_port_dpath #(.DATA_W(DATA_W), .NUM_CSR(NUM_CSR), .SEL_LSB(SEL_LSB)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hostIsData(hostIsData),
    .wrData(hostWrData), .prioDone(prioDone), .stopFlag(stopFlag),
    .txOnQ(txOnQ), .rxOnQ(rxOnQ), .selIdx(selIdx), .rdData(hostRdData),
    .ptdmdQ(ptdmdQ), .dtxQ(dtxQ), .drxQ(drxQ)
  );

  assign txPermit   = txOnQ && !dtxQ && !stopFlag;
  assign rxPermit   = rxOnQ && !drxQ && !stopFlag;
  assign localBusy  = drxQ && !stopFlag;
  assign prioDemand = ptdmdQ;
  assign engineHold = stopFlag;

endmodule

// File: rtl/csr_ctl_port_chk.sv
module csr_ctl_port_chk (
  input logic clk,
  input logic rstN,
  input logic primStop,
  input logic primStart,
  input logic prioDone,
  input logic txBusy,
  input logic rxBusy,
  input logic txPermit,
  input logic rxPermit,
  input logic stopFlag,
  input logic txOnQ,
  input logic rxOnQ,
  input logic dtxQ,
  input logic drxQ,
  input logic ptdmdQ,
  input logic csr0Wr,
  input logic wrPrioBit
);

  // R4
  stop_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    primStop |=> stopFlag);

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!primStop && !primStart) |=> $stable(stopFlag));

  // R5
  stopped_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopFlag |-> (!txPermit && !rxPermit));

  // R6
  tx_permit_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPermit |-> !dtxQ);

  // R7
  tx_frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txOnQ) |-> ($past(stopFlag) || !$past(txBusy)));

  // R7
  tx_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopFlag && !dtxQ) |=> txOnQ);

  // R8
  rx_frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxOnQ) |-> ($past(stopFlag) || !$past(rxBusy)));

  // R8
  rx_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopFlag && !drxQ) |=> rxOnQ);

  // R9
  prio_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csr0Wr && wrPrioBit && !stopFlag) |=> ptdmdQ);

  // R9
  prio_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptdmdQ && !prioDone && !stopFlag) |=> ptdmdQ);

endmodule

bind csr_ctl_port csr_ctl_port_chk u_chk (
  .clk(clk), .rstN(rstN), .primStop(primStop), .primStart(primStart),
  .prioDone(prioDone), .txBusy(txBusy), .rxBusy(rxBusy),
  .txPermit(txPermit), .rxPermit(rxPermit), .stopFlag(stopFlag),
  .txOnQ(txOnQ), .rxOnQ(rxOnQ), .dtxQ(dtxQ), .drxQ(drxQ), .ptdmdQ(ptdmdQ),
  .csr0Wr(strb.csr0Wr), .wrPrioBit(hostWrData[15])
);

// File: tb/csr_ctl_port_bench.sv
`timescale 1ns/1ps
module csr_ctl_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0, hostIsData = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        primStop = 1'b0, primStart = 1'b0, prioDone = 1'b0;
  logic        txBusy = 1'b0, rxBusy = 1'b0;
  logic        txPermit, rxPermit, localBusy, prioDemand, engineHold;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  csr_ctl_port u_csr_ctl_port (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostIsData(hostIsData),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .primStop(primStop),
    .primStart(primStart), .prioDone(prioDone), .txBusy(txBusy), .rxBusy(rxBusy),
    .txPermit(txPermit), .rxPermit(rxPermit), .localBusy(localBusy),
    .prioDemand(prioDemand), .engineHold(engineHold)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic isData, input logic [15:0] val);
    hostIsData = isData; hostWrData = val; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hread(input logic isData, output logic [15:0] val);
    hostIsData = isData;
    #1 val = hostRdData;
  endtask

  task automatic readCsr0(input string req, input logic [15:0] exp);
    logic [15:0] v;
    hwrite(1'b0, 16'h0000);
    hread(1'b1, v);
    chk(req, v, exp);
  endtask

  task automatic pulseStart();
    primStart = 1'b1; @(negedge clk); primStart = 1'b0;
    cyc(1);
  endtask

  task automatic testReset();
    logic [15:0] v;
    hread(1'b0, v);
    chk("R1 pointer reset", v, 16'h0000);
    hread(1'b1, v);
    chk("R3 csr0 reset", v, 16'h4000);
    chk("R5 permits at reset", {14'd0, txPermit, rxPermit}, 16'h0000);
    chk("R5 engineHold at reset", {15'd0, engineHold}, 16'h0001);
  endtask

  task automatic testStart();
    pulseStart();
    readCsr0("R4 start clears stop, R7/R8 on flags set", 16'h0030);
    chk("R6 permits after start", {14'd0, txPermit, rxPermit}, 16'h0003);
    chk("R5 engineHold after start", {15'd0, engineHold}, 16'h0000);
  endtask

  task automatic testPlain();
    logic [15:0] v;
    hwrite(1'b0, 16'h0002); hwrite(1'b1, 16'hA5A5);
    hwrite(1'b0, 16'h0004); hwrite(1'b1, 16'h1234);
    hwrite(1'b0, 16'hFFFE); hwrite(1'b1, 16'h0F0F);
    hread(1'b0, v);
    chk("R1 pointer readback", v, 16'hFFFE);
    hwrite(1'b0, 16'h0002); hread(1'b1, v);
    chk("R2 reg1 readback", v, 16'hA5A5);
    hwrite(1'b0, 16'h0005); hread(1'b1, v);
    chk("R2 bit0 ignored selects reg2", v, 16'h1234);
    hwrite(1'b0, 16'h000E); hread(1'b1, v);
    chk("R2 high bits ignored, reg7", v, 16'h0F0F);
    hwrite(1'b0, 16'h0010); hread(1'b1, v);
    chk("R2 ptr 0x10 selects csr0", v, 16'h0030);
  endtask

  task automatic testTxIdle();
    hwrite(1'b0, 16'h0000);
    hwrite(1'b1, 16'h2000);
    chk("R6 txPermit low after disable", {15'd0, txPermit}, 16'h0000);
    cyc(1);
    readCsr0("R7 txon clears when idle", 16'h2010);
    hwrite(1'b1, 16'h0000);
    cyc(1);
    readCsr0("R7 txon sets after enable", 16'h0030);
  endtask

  task automatic testTxBusy();
    txBusy = 1'b1;
    hwrite(1'b0, 16'h0000);
    hwrite(1'b1, 16'h2000);
    cyc(3);
    readCsr0("R7 txon held during frame", 16'h2030);
    chk("R6 txPermit blocked mid-frame", {15'd0, txPermit}, 16'h0000);
    txBusy = 1'b0;
    cyc(1);
    readCsr0("R7 txon clears at frame end", 16'h2010);
    hwrite(1'b1, 16'h0000);
    cyc(1);
    readCsr0("R7 tx restore", 16'h0030);
  endtask

  task automatic testRx();
    rxBusy = 1'b1;
    hwrite(1'b0, 16'h0000);
    hwrite(1'b1, 16'h1000);
    chk("R8 localBusy set", {14'd0, localBusy, rxPermit}, 16'h0002);
    cyc(2);
    readCsr0("R8 rxon held during frame", 16'h1030);
    rxBusy = 1'b0;
    cyc(1);
    readCsr0("R8 rxon clears at frame end", 16'h1020);
    hwrite(1'b1, 16'h0000);
    cyc(1);
    readCsr0("R8 rx restore", 16'h0030);
    chk("R8 rxPermit and localBusy after restore", {14'd0, localBusy, rxPermit}, 16'h0001);
  endtask

  task automatic testPrio();
    hwrite(1'b0, 16'h0000);
    hwrite(1'b1, 16'h8000);
    chk("R9 prioDemand set", {15'd0, prioDemand}, 16'h0001);
    hwrite(1'b1, 16'h0000);
    readCsr0("R9 write 0 keeps demand", 16'h8030);
    prioDone = 1'b1; @(negedge clk); prioDone = 1'b0;
    chk("R9 prioDone clears", {15'd0, prioDemand}, 16'h0000);
    prioDone = 1'b1;
    hwrite(1'b1, 16'h8000);
    prioDone = 1'b0;
    chk("R9 set wins over clear", {15'd0, prioDemand}, 16'h0001);
    prioDone = 1'b1; @(negedge clk); prioDone = 1'b0;
  endtask

  task automatic testReadOnly();
    hwrite(1'b0, 16'h0000);
    hwrite(1'b1, 16'h4000);
    readCsr0("R4 write to stop bit ignored", 16'h0030);
    hwrite(1'b1, 16'h0FCF);
    cyc(1);
    readCsr0("R7 write to on bits ignored", 16'h0030);
  endtask

  task automatic testStop();
    logic [15:0] v;
    hwrite(1'b0, 16'h0000);
    hwrite(1'b1, 16'hB000);
    primStop = 1'b1; @(negedge clk); primStop = 1'b0;
    chk("R5 permits off when stopped", {13'd0, engineHold, txPermit, rxPermit}, 16'h0004);
    cyc(1);
    readCsr0("R5 stop clears state", 16'h4000);
    hwrite(1'b1, 16'hB000);
    cyc(1);
    readCsr0("R5 csr0 write ignored while stopped", 16'h4000);
    hwrite(1'b0, 16'h0006); hwrite(1'b1, 16'h5A5A); hread(1'b1, v);
    chk("R5 plain reg writable while stopped", v, 16'h5A5A);
    primStop = 1'b1; primStart = 1'b1; @(negedge clk);
    primStop = 1'b0; primStart = 1'b0;
    chk("R4 stop wins over start", {15'd0, engineHold}, 16'h0001);
    pulseStart();
    readCsr0("R4 restart", 16'h0030);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    testReset();
    testStart();
    testPlain();
    testTxIdle();
    testTxBusy();
    testRx();
    testPrio();
    testReadOnly();
    testStop();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule